// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block arbitrates interrupt requests raised by four timer channels and presents a single request line to the processor. A single-cycle strobe from a channel marks that channel pending. Priority between channels is fixed: the lowest channel index wins. The controller takes part in a board-level priority chain. An enable arrives on `iei_i` and is passed on through `ieo_o`, so that devices further down the chain stay quiet while this one has work outstanding or is being serviced.

When the processor runs an acknowledge cycle (`m1_i` and `iorq_i` both high), the winning channel is promoted from pending to in-service. Its 8-bit vector is returned on `vec_o`, qualified by `vec_vld_o`. The vector is built from a software-loaded base in bits 7:3, the channel index in bits 2:1, and a zero in bit 0. The controller snoops opcode fetches (`m1_i` high, `iorq_i` low) on `bus_data_i`. The two-byte return-from-interrupt sequence 0xED, 0x4D retires the highest-priority channel in service.

The vector leaves as a stream with a valid qualifier and no ready. An acknowledge cycle cannot be stalled, so there is no back-pressure. The vector is held stable for as long as the acknowledge stays asserted, and the consumer must take it in that window. `int_o` is active high; the board pulls a shared open-drain request line low while it is asserted.

Top module: `chain_irq_ctrl`

## Requirements
- R1: After reset no channel is pending or in service, the vector base is 0, `int_o` and `vec_vld_o` are 0, and `ieo_o` equals `iei_i`.
- R2: A high bit in `chan_req_i` at a rising edge makes that channel pending from the next cycle. A pending channel drives `int_o` high when it is eligible. A channel is eligible when `iei_i` is high and neither it nor any lower-index channel is in service.
- R3: `int_o` is low in every cycle in which `iei_i` is low.
- R4: The first cycle of an acknowledge is a cycle with `m1_i`=1 and `iorq_i`=1 that follows a cycle without both. If an eligible channel exists in that first cycle, `vec_vld_o` rises one cycle later. It stays high while the acknowledge holds and falls the cycle after the acknowledge drops. If no eligible channel exists, `vec_vld_o` stays low.
- R5: The acknowledged channel stops being pending and becomes in service at the same edge that raises `vec_vld_o`.
- R6: When several eligible channels are pending, the one with the lowest index is acknowledged.
- R7: `vec_o` = {base[4:0], channel[1:0], 1'b0} while `vec_vld_o` is high. The base is replaced by `base_i` at an edge where `base_wr_i` is high.
- R8: `ieo_o` is 0 while any channel is in service. It is also 0 while any channel is pending, unless the most recent opcode fetch carried 0xED. Otherwise `ieo_o` equals `iei_i`.
- R9: An opcode fetch of 0xED immediately followed by an opcode fetch of 0x4D, with `iei_i` high during the 0x4D fetch, clears the lowest-index in-service channel. Any other opcode in between cancels the sequence. `iei_i` low during the 0x4D fetch also prevents the clear.
- R10: A pending channel with a lower index than every in-service channel may interrupt (nesting). A pending channel at or above the index of an in-service channel cannot raise `int_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| chan_req_i | input | 4 | Per-channel request strobes |
| base_wr_i | input | 1 | Load strobe for the vector base |
| base_i | input | 5 | New vector base (vector bits 7:3) |
| m1_i | input | 1 | Processor machine-cycle-one qualifier |
| iorq_i | input | 1 | Processor I/O request qualifier |
| bus_data_i | input | 8 | Snooped data bus for opcode fetches |
| iei_i | input | 1 | Priority chain enable in |
| ieo_o | output | 1 | Priority chain enable out |
| int_o | output | 1 | Interrupt request, active high |
| vec_vld_o | output | 1 | Vector valid |
| vec_o | output | 8 | Interrupt vector |

## Verification
`int_o` and `ieo_o` depend combinationally on `iei_i` and on registered state. Their values are therefore due in the same cycle as a chain-enable change, and one edge after a request strobe, acknowledge start or fetch edge. `vec_vld_o` and `vec_o` are registered and are due one edge after the first acknowledge cycle. The in-service change made by a 0x4D fetch shows on `ieo_o` and `int_o` one edge after that fetch. The bench drives inputs 1 ns after a rising edge and compares against a requirement-level model at the following falling edge. The model advances only at the rising edge, so every comparison lands in the cycle in which the result is due.

// File: rtl/chain_irq_pkg.sv
package chain_irq_pkg;
  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RETURN = 8'h4D;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_ACK   = 2'd2
  } bus_cyc_e;

  function automatic bus_cyc_e classify(input logic m1, input logic iorq);
    if (m1 && iorq)  return CYC_ACK;
    if (m1 && !iorq) return CYC_FETCH;
    return CYC_IDLE;
  endfunction
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_chan_slot.sv
module irq_chan_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_set_i,
  input  logic ack_take_i,
  input  logic ret_clr_i,
  output logic pend_o,
  output logic isv_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      isv_o  <= 1'b0;
    end else begin
      pend_o <= (pend_o & ~ack_take_i) | req_set_i;
      isv_o  <= (isv_o & ~ret_clr_i) | ack_take_i;
    end
  end
endmodule

// File: rtl/bus_cycle_decode.sv
module bus_cycle_decode
  import chain_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          m1_i,
  input  logic          iorq_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_act_o,
  output logic          ack_start_o,
  output logic          prefix_seen_o,
  output logic          ret_hit_o
);
  bus_cyc_e cyc;
  logic     ack_q, fetch_q, fetch_start;

  assign cyc         = classify(m1_i, iorq_i);
  assign ack_act_o   = (cyc == CYC_ACK);
  assign ack_start_o = ack_act_o & ~ack_q;
  assign fetch_start = (cyc == CYC_FETCH) & ~fetch_q;
  assign ret_hit_o   = fetch_start & prefix_seen_o & (data_i == OP_RETURN);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ack_q         <= 1'b0;
      fetch_q       <= 1'b0;
      prefix_seen_o <= 1'b0;
    end else begin
      ack_q   <= ack_act_o;
      fetch_q <= (cyc == CYC_FETCH);
      if (fetch_start) prefix_seen_o <= (data_i == OP_PREFIX);
    end
  end
endmodule

// File: rtl/chain_irq_ctrl.sv
module chain_irq_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int BW  = DW - 1 - CW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] chan_req_i,
  input  logic           base_wr_i,
  input  logic [BW-1:0]  base_i,
  input  logic           m1_i,
  input  logic           iorq_i,
  input  logic [DW-1:0]  bus_data_i,
  input  logic           iei_i,
  output logic           ieo_o,
  output logic           int_o,
  output logic           vec_vld_o,
  output logic [DW-1:0]  vec_o
);
  logic [NCH-1:0] pend_q, isv_q, blocked, eligible;
  logic [BW-1:0]  base_q;
  logic           win_found, svc_found;
  logic [CW-1:0]  win_idx, svc_idx;
  logic           ack_act, ack_start, prefix_seen, ret_hit;
  logic           ack_take, ret_clr;

  bus_cycle_decode #(.DW(DW)) dec_i (
    .clk_i, .rst_ni, .m1_i, .iorq_i, .data_i(bus_data_i),
    .ack_act_o(ack_act), .ack_start_o(ack_start),
    .prefix_seen_o(prefix_seen), .ret_hit_o(ret_hit)
  );

  // A channel is blocked by itself or any lower index in service.
  always_comb begin
    blocked[0] = isv_q[0];
    for (int i = 1; i < NCH; i++) blocked[i] = blocked[i-1] | isv_q[i];
  end
  assign eligible = pend_q & ~blocked & {NCH{iei_i}};

  irq_lowest_pick #(.N(NCH), .IW(CW)) win_pick_i (
    .req_i(eligible), .found_o(win_found), .idx_o(win_idx)
  );
  irq_lowest_pick #(.N(NCH), .IW(CW)) svc_pick_i (
    .req_i(isv_q), .found_o(svc_found), .idx_o(svc_idx)
  );

  assign ack_take = ack_start & win_found;
  assign ret_clr  = ret_hit & iei_i & svc_found;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    irq_chan_slot slot_i (
      .clk_i, .rst_ni,
      .req_set_i (chan_req_i[g]),
      .ack_take_i(ack_take && (win_idx == CW'(g))),
      .ret_clr_i (ret_clr && (svc_idx == CW'(g))),
      .pend_o    (pend_q[g]),
      .isv_o     (isv_q[g])
    );
  end

  assign int_o = win_found;
  assign ieo_o = iei_i & ~(|isv_q) & (~(|pend_q) | prefix_seen);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      base_q    <= '0;
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
    end else begin
      if (base_wr_i) base_q <= base_i;
      if (!ack_act) begin
        vec_vld_o <= 1'b0;
      end else if (ack_start) begin
        vec_vld_o <= win_found;
        vec_o     <= {base_q, win_idx, 1'b0};
      end
    end
  end
endmodule

// File: rtl/chain_irq_ctrl_chk.sv
module chain_irq_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int CW  = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           m1_i,
  input logic           iorq_i,
  input logic           iei_i,
  input logic           ieo_o,
  input logic           int_o,
  input logic           vec_vld_o,
  input logic [DW-1:0]  vec_o,
  input logic [NCH-1:0] isv_i
);
  // R3
  int_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iei_i |-> !int_o);
  // R8
  ieo_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iei_i || (|isv_i)) |-> !ieo_o);
  // R4
  vld_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(m1_i && iorq_i));
  // R4
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld_o && $past(vec_vld_o)) |-> $stable(vec_o));
  // R7
  vec_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> !vec_o[0]);
  // R5
  acked_in_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_vld_o) |-> isv_i[vec_o[CW:1]]);
  // R9
  svc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(isv_i) > $countones($past(isv_i))) |-> $rose(vec_vld_o));
endmodule

bind chain_irq_ctrl chain_irq_ctrl_chk #(.NCH(NCH), .DW(DW), .CW(CW)) chk_i (
  .clk_i, .rst_ni, .m1_i, .iorq_i, .iei_i, .ieo_o, .int_o,
  .vec_vld_o, .vec_o, .isv_i(isv_q)
);

// File: tb/chain_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module chain_irq_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int BW  = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] chan_req;
  logic       base_wr;
  logic [4:0] base;
  logic       m1, iorq, iei;
  logic [7:0] bus_data;
  logic       ieo, irq, vld;
  logic [7:0] vec;

  always #2.5 clk = ~clk;

  chain_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_req_i(chan_req), .base_wr_i(base_wr),
    .base_i(base), .m1_i(m1), .iorq_i(iorq), .bus_data_i(bus_data),
    .iei_i(iei), .ieo_o(ieo), .int_o(irq), .vec_vld_o(vld), .vec_o(vec)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [3:0] m_pend, m_isv;
  logic [4:0] m_base;
  logic       m_ed, m_ackq, m_fq, m_vld;
  logic [7:0] m_vec, last_vec;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_win();
    for (int i = 0; i < NCH; i++) begin
      logic [3:0] mask = 4'((1 << (i + 1)) - 1);
      if (m_pend[i] && iei && ((m_isv & mask) == 4'd0)) return i;
    end
    return -1;
  endfunction

  function automatic logic m_ieo();
    return iei && (m_isv == 4'd0) && ((m_pend == 4'd0) || m_ed);
  endfunction

  task automatic model_step();
    logic ack = m1 && iorq;
    logic fch = m1 && !iorq;
    int   w   = m_win();
    if (!ack) m_vld = 1'b0;
    else if (!m_ackq) begin
      m_vld = (w >= 0);
      if (w >= 0) begin
        m_vec = {m_base, 2'(w), 1'b0};
        m_pend[w] = 1'b0;
        m_isv[w]  = 1'b1;
      end
    end
    m_pend = m_pend | chan_req;
    if (fch && !m_fq) begin
      if (bus_data == 8'hED) m_ed = 1'b1;
      else begin
        if (bus_data == 8'h4D && m_ed && iei) begin
          for (int i = 0; i < NCH; i++)
            if (m_isv[i]) begin m_isv[i] = 1'b0; break; end
        end
        m_ed = 1'b0;
      end
    end
    if (base_wr) m_base = base;
    m_ackq = ack;
    m_fq   = fch;
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R2", "int_o", {7'd0, irq}, {7'd0, m_win() >= 0});
    chk("R8", "ieo_o", {7'd0, ieo}, {7'd0, m_ieo()});
    chk("R4", "vec_vld_o", {7'd0, vld}, {7'd0, m_vld});
    if (m_vld) begin
      chk("R7", "vec_o", vec, m_vec);
      last_vec = vec;
    end
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic request(input logic [3:0] m);
    chan_req = m; cyc(); chan_req = 4'd0;
  endtask
  task automatic ack();
    m1 = 1'b1; iorq = 1'b1; cyc(); cyc();
    m1 = 1'b0; iorq = 1'b0; cyc();
  endtask
  task automatic fetch(input logic [7:0] op);
    m1 = 1'b1; iorq = 1'b0; bus_data = op; cyc();
    m1 = 1'b0; cyc();
  endtask
  task automatic reti();
    fetch(8'hED); fetch(8'h4D);
  endtask
  task automatic wrbase(input logic [4:0] b);
    base_wr = 1'b1; base = b; cyc(); base_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chan_req = '0; base_wr = 1'b0; base = '0;
    m1 = 1'b0; iorq = 1'b0; iei = 1'b1; bus_data = '0;
    m_pend = '0; m_isv = '0; m_base = '0; m_ed = 1'b0;
    m_ackq = 1'b0; m_fq = 1'b0; m_vld = 1'b0; m_vec = '0; last_vec = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, chain enable passes both ways
    #1;
    chk("R1", "int_o", {7'd0, irq}, 8'd0);
    chk("R1", "vec_vld_o", {7'd0, vld}, 8'd0);
    chk("R1", "ieo_o hi", {7'd0, ieo}, 8'd1);
    iei = 1'b0; #1;
    chk("R1", "ieo_o lo", {7'd0, ieo}, 8'd0);
    iei = 1'b1;
    cyc();

    // R7: every base value with every channel
    for (int b = 0; b < 32; b++) begin
      for (int c = 0; c < NCH; c++) begin
        wrbase(5'(b));
        request(4'(1 << c));
        ack();
        chk("R7", "vector", last_vec, {5'(b), 2'(c), 1'b0});
        // R5: request consumed, chain closed while in service
        chk("R5", "int_o after ack", {7'd0, irq}, 8'd0);
        chk("R5", "ieo_o after ack", {7'd0, ieo}, 8'd0);
        reti();
        chk("R9", "ieo_o after return", {7'd0, ieo}, 8'd1);
      end
    end

    // R6: every pending pattern, served lowest first
    wrbase(5'd0);
    for (int p = 1; p < 16; p++) begin
      request(4'(p));
      while (m_pend != 4'd0) begin
        int lo = 0;
        for (int i = NCH - 1; i >= 0; i--) if (m_pend[i]) lo = i;
        ack();
        chk("R6", "winner", {6'd0, last_vec[2:1]}, 8'(lo));
        // R10: remaining higher-index channels blocked
        chk("R10", "int_o blocked", {7'd0, irq}, 8'd0);
        reti();
      end
    end

    // R10: nesting, channel 0 over channel 2 in service
    request(4'b0100); ack();
    request(4'b0001);
    chk("R10", "nested int_o", {7'd0, irq}, 8'd1);
    ack();
    chk("R6", "nested winner", {6'd0, last_vec[2:1]}, 8'd0);
    request(4'b0100);
    chk("R10", "self blocked", {7'd0, irq}, 8'd0);
    reti();
    chk("R9", "ch2 still served", {7'd0, ieo}, 8'd0);
    chk("R10", "ch2 still blocked", {7'd0, irq}, 8'd0);
    reti();
    chk("R2", "ch2 re-request", {7'd0, irq}, 8'd1);
    ack(); reti();

    // R3 / R4: chain disabled blocks request and acknowledge
    iei = 1'b0;
    request(4'b0010);
    chk("R3", "int_o gated", {7'd0, irq}, 8'd0);
    ack();
    iei = 1'b1; #1;
    chk("R4", "still pending", {7'd0, irq}, 8'd1);
    ack();
    iei = 1'b0; reti(); iei = 1'b1; #1;
    chk("R9", "no clear with iei low", {7'd0, ieo}, 8'd0);
    reti();
    chk("R9", "cleared", {7'd0, ieo}, 8'd1);

    // R8 / R9: prefix releases chain; broken sequence does not clear
    request(4'b1000);
    chk("R8", "pending closes", {7'd0, ieo}, 8'd0);
    fetch(8'hED);
    chk("R8", "prefix opens", {7'd0, ieo}, 8'd1);
    fetch(8'h00);
    chk("R8", "prefix cancelled", {7'd0, ieo}, 8'd0);
    ack();
    fetch(8'hED); fetch(8'h00); fetch(8'h4D);
    chk("R9", "broken sequence", {7'd0, ieo}, 8'd0);
    reti();
    chk("R9", "final clear", {7'd0, ieo}, 8'd1);
    cyc();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule